// File: doc/BRIEF.md
# Rectangular Blit Address Sequencer

This block generates the address streams of one general-purpose blit channel. From a latched set of configuration values it produces a sequence of source byte reads and destination byte writes that walk a rectangle: a line of a given length, then a jump by a per-side line pitch to the start of the next line. It repeats until a down-counting byte count runs out. Each address is offered on its own valid/ready channel. A separate data unit consumes them and combines or fills the data. This block issues at most one request at a time: the source read for a byte, when one is needed, comes before the destination write of that byte.

Three source modes exist. A plain copy reads one source byte per destination byte. A simple fill issues no source reads. A masked fill reads one mask byte per eight destination bytes, and its mask line advances by one eighth of the destination pitch. An optional gap mode makes the source read a group of 1, 2, 4 or 8 bytes and then step over a gap of the same size. A signed 16-byte-granular displacement can be applied to the bus address of either side. The live position registers stay free of that displacement. Software sees busy, a one-cycle done pulse, a refused-start pulse, and the live count and position values.

Top module: `blit_addr_seq`

## Requirements
- R1: A start while idle loads the configuration and raises busy_o from the next cycle. After the write handshake of the final byte, busy_o falls and done_o pulses for exactly one cycle with count_o reading all ones (0xFFFFFF).
- R2: count_o is loaded with count_m1_i and drops by one on every accepted destination write, so a transfer makes count_m1_i+1 writes.
- R3: With line_len_i = 0 the rectangle is ignored. Destination write k goes to dst_base_i+k and, in copy mode, source read k goes to src_base_i+k.
- R4: With line length L > 0, byte k lies in line k/L at position k%L. The destination address is dst_base_i + line*dst_stride_i + position. In copy mode the source address is src_base_i + line*src_stride_i + position.
- R5: With skip_en_i set and group size N = 1<<skip_sel_i (codes 0..3 give 1, 2, 4, 8 bytes), source read m of a line goes to line start + (m/N)*2N + m%N. The group phase restarts at each line start.
- R6: When off_src_en_i (or off_dst_en_i) is set, the source (or destination) bus address equals the unshifted address plus (pos_off_i & 0x3FFFF0) minus (neg_off_i & 0x3FFFF0), modulo 2^24. src_cur_o and dst_cur_o never include this displacement and read the base addresses right after a start.
- R7: With simple_fill_i set, no source read is issued, whatever the source settings; simple fill takes precedence over masked_fill_i.
- R8: With masked_fill_i set (and simple_fill_i clear), one source read precedes every destination byte whose line position is a multiple of 8. Mask read m of line j goes to src_base_i + j*(dst_stride_i>>3) + m, or to the gap-mode address of R5. src_stride_i is ignored.
- R9: abort_i while busy returns the block to idle on the next edge with no done_o pulse; count_o keeps the value it had reached.
- R10: A start with a nonzero line length larger than dst_stride_i, or larger than src_stride_i in copy mode, is refused: busy_o stays low and cfg_err_o pulses for one cycle.
- R11: src_valid_o and dst_valid_o are never high together, and a request holds its address until accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request (acted on when idle) |
| abort_i | input | 1 | Abort the running transfer |
| line_len_i | input | 12 | Line length in bytes, 0 = contiguous |
| src_stride_i | input | 12 | Source line pitch in bytes |
| dst_stride_i | input | 12 | Destination line pitch in bytes |
| count_m1_i | input | 24 | Total bytes minus one |
| src_base_i | input | 24 | Source start address |
| dst_base_i | input | 24 | Destination start address |
| pos_off_i | input | 24 | Added displacement (16-byte granular) |
| neg_off_i | input | 24 | Subtracted displacement (16-byte granular) |
| skip_en_i | input | 1 | Source gap mode enable |
| skip_sel_i | input | 2 | Gap group size code, N = 1<<code |
| off_src_en_i | input | 1 | Apply displacement to source bus address |
| off_dst_en_i | input | 1 | Apply displacement to destination bus address |
| simple_fill_i | input | 1 | Simple fill, no source reads |
| masked_fill_i | input | 1 | Masked fill, one mask byte per 8 destination bytes |
| src_valid_o | output | 1 | Source read request |
| src_ready_i | input | 1 | Source read accepted |
| src_addr_o | output | 24 | Source bus byte address |
| dst_valid_o | output | 1 | Destination write request |
| dst_ready_i | input | 1 | Destination write accepted |
| dst_addr_o | output | 24 | Destination bus byte address |
| busy_o | output | 1 | Transfer running |
| done_o | output | 1 | One-cycle completion pulse |
| cfg_err_o | output | 1 | One-cycle refused-start pulse |
| count_o | output | 24 | Live remaining count minus one |
| src_cur_o | output | 24 | Live source position, without displacement |
| dst_cur_o | output | 24 | Live destination position, without displacement |

## Verification
The bench uses the default widths: 24-bit addresses and count, 12-bit line and pitch values, and the displacement mask over bits 21:4. The transfers are short, so every source mode, with simple and masked fill requested together, can be crossed with gap mode off and all four group sizes, and with contiguous, short and long lines. A long line spans two mask bytes. Randomised stalls on both ready inputs exercise request holding. The displacement enables rotate across the sweep. Separate runs cover abort at mid-transfer and refused configurations, including ones where the too-small source pitch is legally ignored.

// File: rtl/blit_pkg.sv
package blit_pkg;
  typedef enum logic [1:0] {
    FILL_NONE   = 2'd0,
    FILL_SIMPLE = 2'd1,
    FILL_MASK   = 2'd2
  } fill_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SRC  = 2'd1,
    ST_DST  = 2'd2
  } seq_st_e;
endpackage

// File: rtl/blit_cfg_check.sv
module blit_cfg_check #(
  parameter int SW = 12
) (
  input  logic [SW-1:0] line_len_i,
  input  logic [SW-1:0] src_stride_i,
  input  logic [SW-1:0] dst_stride_i,
  input  logic          src_used_i,
  output logic          err_o
);
  logic lined;
  assign lined = (line_len_i != '0);
  assign err_o = lined && ((line_len_i > dst_stride_i) ||
                           (src_used_i && (line_len_i > src_stride_i)));
endmodule

// File: rtl/blit_src_step.sv
module blit_src_step #(
  parameter int AW = 24
) (
  input  logic [AW-1:0] cur_i,
  input  logic          skip_en_i,
  input  logic [1:0]    sel_i,
  input  logic [2:0]    grp_i,
  output logic [AW-1:0] nxt_o,
  output logic [2:0]    grp_o
);
  logic [3:0] grp_n;
  logic       wrap;
  assign grp_n = 4'd1 << sel_i;
  assign wrap  = skip_en_i && ({1'b0, grp_i} == grp_n - 4'd1);
  // end of a group jumps over a gap of equal size
  assign nxt_o = cur_i + (wrap ? AW'(grp_n) + AW'(1) : AW'(1));
  assign grp_o = (wrap || !skip_en_i) ? 3'd0 : grp_i + 3'd1;
endmodule

// File: rtl/blit_addr_offset.sv
module blit_addr_offset #(
  parameter int              AW   = 24,
  parameter logic [AW-1:0]   MASK = 24'h3FFFF0
) (
  input  logic [AW-1:0] addr_i,
  input  logic [AW-1:0] pos_i,
  input  logic [AW-1:0] neg_i,
  input  logic          en_i,
  output logic [AW-1:0] eff_o
);
  assign eff_o = en_i ? addr_i + (pos_i & MASK) - (neg_i & MASK) : addr_i;
endmodule

// File: rtl/blit_addr_seq.sv
module blit_addr_seq
  import blit_pkg::*;
#(
  parameter int AW      = 24,
  parameter int SW      = 12,
  parameter int CW      = 24,
  parameter int OFF_LSB = 4,
  parameter int OFF_MSB = 21
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          abort_i,
  input  logic [SW-1:0] line_len_i,
  input  logic [SW-1:0] src_stride_i,
  input  logic [SW-1:0] dst_stride_i,
  input  logic [CW-1:0] count_m1_i,
  input  logic [AW-1:0] src_base_i,
  input  logic [AW-1:0] dst_base_i,
  input  logic [AW-1:0] pos_off_i,
  input  logic [AW-1:0] neg_off_i,
  input  logic          skip_en_i,
  input  logic [1:0]    skip_sel_i,
  input  logic          off_src_en_i,
  input  logic          off_dst_en_i,
  input  logic          simple_fill_i,
  input  logic          masked_fill_i,
  output logic          src_valid_o,
  input  logic          src_ready_i,
  output logic [AW-1:0] src_addr_o,
  output logic          dst_valid_o,
  input  logic          dst_ready_i,
  output logic [AW-1:0] dst_addr_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          cfg_err_o,
  output logic [CW-1:0] count_o,
  output logic [AW-1:0] src_cur_o,
  output logic [AW-1:0] dst_cur_o
);
  localparam logic [AW-1:0] OFF_MASK =
    AW'(((64'd1 << (OFF_MSB + 1)) - 64'd1) ^ ((64'd1 << OFF_LSB) - 64'd1));
  localparam int SIDES = 2;

  seq_st_e       st_q;
  fill_e         mode_d, mode_q;
  logic          skip_en_q, off_src_q, off_dst_q;
  logic [1:0]    skip_sel_q;
  logic [AW-1:0] pos_q, neg_q;
  logic [SW-1:0] line_q, sstep_q, dstep_q, lpos_q;
  logic [AW-1:0] src_line_q, dst_line_q, src_cur_q, dst_cur_q;
  logic [CW-1:0] cnt_q;
  logic [2:0]    grp_q, bit_q;
  logic          done_q, cfg_err_q;

  logic          cfg_err;
  logic [AW-1:0] src_nxt;
  logic [2:0]    grp_nxt, bit_nxt;
  logic          line_end, last;
  logic [AW-1:0] src_line_nxt, dst_line_nxt;
  seq_st_e       st_after_dst;

  // simple fill wins over masked fill
  assign mode_d = simple_fill_i ? FILL_SIMPLE : (masked_fill_i ? FILL_MASK : FILL_NONE);

  blit_cfg_check #(.SW(SW)) u_cfg (
    .line_len_i  (line_len_i),
    .src_stride_i(src_stride_i),
    .dst_stride_i(dst_stride_i),
    .src_used_i  (mode_d == FILL_NONE),
    .err_o       (cfg_err)
  );

  blit_src_step #(.AW(AW)) u_step (
    .cur_i    (src_cur_q),
    .skip_en_i(skip_en_q),
    .sel_i    (skip_sel_q),
    .grp_i    (grp_q),
    .nxt_o    (src_nxt),
    .grp_o    (grp_nxt)
  );

  logic [AW-1:0] side_cur [SIDES];
  logic          side_en  [SIDES];
  logic [AW-1:0] side_eff [SIDES];
  assign side_cur[0] = src_cur_q;
  assign side_cur[1] = dst_cur_q;
  assign side_en[0]  = off_src_q;
  assign side_en[1]  = off_dst_q;

  for (genvar s = 0; s < SIDES; s++) begin : g_off
    blit_addr_offset #(.AW(AW), .MASK(OFF_MASK)) u_off (
      .addr_i(side_cur[s]),
      .pos_i (pos_q),
      .neg_i (neg_q),
      .en_i  (side_en[s]),
      .eff_o (side_eff[s])
    );
  end

  assign line_end     = (line_q != '0) && (lpos_q == line_q - SW'(1));
  assign last         = (cnt_q == '0);
  assign bit_nxt      = line_end ? 3'd0 : bit_q + 3'd1;
  assign src_line_nxt = src_line_q + AW'(sstep_q);
  assign dst_line_nxt = dst_line_q + AW'(dstep_q);

  always_comb begin
    unique case (mode_q)
      FILL_SIMPLE: st_after_dst = ST_DST;
      FILL_MASK:   st_after_dst = (bit_nxt == 3'd0) ? ST_SRC : ST_DST;
      default:     st_after_dst = ST_SRC;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      mode_q     <= FILL_NONE;
      skip_en_q  <= 1'b0;
      skip_sel_q <= '0;
      off_src_q  <= 1'b0;
      off_dst_q  <= 1'b0;
      pos_q      <= '0;
      neg_q      <= '0;
      line_q     <= '0;
      sstep_q    <= '0;
      dstep_q    <= '0;
      lpos_q     <= '0;
      src_line_q <= '0;
      dst_line_q <= '0;
      src_cur_q  <= '0;
      dst_cur_q  <= '0;
      cnt_q      <= '0;
      grp_q      <= '0;
      bit_q      <= '0;
      done_q     <= 1'b0;
      cfg_err_q  <= 1'b0;
    end else begin
      done_q    <= 1'b0;
      cfg_err_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (start_i) begin
            if (cfg_err) begin
              cfg_err_q <= 1'b1;
            end else begin
              mode_q     <= mode_d;
              skip_en_q  <= skip_en_i;
              skip_sel_q <= skip_sel_i;
              off_src_q  <= off_src_en_i;
              off_dst_q  <= off_dst_en_i;
              pos_q      <= pos_off_i;
              neg_q      <= neg_off_i;
              line_q     <= line_len_i;
              // mask lines advance at one eighth of the destination pitch
              sstep_q    <= (mode_d == FILL_MASK) ? (dst_stride_i >> 3) : src_stride_i;
              dstep_q    <= dst_stride_i;
              lpos_q     <= '0;
              src_line_q <= src_base_i;
              dst_line_q <= dst_base_i;
              src_cur_q  <= src_base_i;
              dst_cur_q  <= dst_base_i;
              cnt_q      <= count_m1_i;
              grp_q      <= '0;
              bit_q      <= '0;
              st_q       <= (mode_d == FILL_SIMPLE) ? ST_DST : ST_SRC;
            end
          end
        end
        ST_SRC: begin
          if (abort_i) begin
            st_q <= ST_IDLE;
          end else if (src_ready_i) begin
            src_cur_q <= src_nxt;
            grp_q     <= grp_nxt;
            st_q      <= ST_DST;
          end
        end
        ST_DST: begin
          if (abort_i) begin
            st_q <= ST_IDLE;
          end else if (dst_ready_i) begin
            cnt_q <= cnt_q - CW'(1);
            bit_q <= bit_nxt;
            if (line_end) begin
              dst_line_q <= dst_line_nxt;
              dst_cur_q  <= dst_line_nxt;
              src_line_q <= src_line_nxt;
              src_cur_q  <= src_line_nxt;
              lpos_q     <= '0;
              grp_q      <= '0;
            end else begin
              dst_cur_q <= dst_cur_q + AW'(1);
              lpos_q    <= lpos_q + SW'(1);
            end
            if (last) begin
              st_q   <= ST_IDLE;
              done_q <= 1'b1;
            end else begin
              st_q <= st_after_dst;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign src_valid_o = (st_q == ST_SRC);
  assign dst_valid_o = (st_q == ST_DST);
  assign src_addr_o  = side_eff[0];
  assign dst_addr_o  = side_eff[1];
  assign busy_o      = (st_q != ST_IDLE);
  assign done_o      = done_q;
  assign cfg_err_o   = cfg_err_q;
  assign count_o     = cnt_q;
  assign src_cur_o   = src_cur_q;
  assign dst_cur_o   = dst_cur_q;
endmodule

// File: rtl/blit_addr_seq_chk.sv
module blit_addr_seq_chk
  import blit_pkg::*;
#(
  parameter int AW = 24,
  parameter int CW = 24
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          abort_i,
  input logic          src_valid_o,
  input logic          src_ready_i,
  input logic [AW-1:0] src_addr_o,
  input logic          dst_valid_o,
  input logic          dst_ready_i,
  input logic [AW-1:0] dst_addr_o,
  input logic          busy_o,
  input logic          done_o,
  input logic          cfg_err_o,
  input logic [CW-1:0] count_o,
  input fill_e         mode_q
);
  assert_req_exclusive_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({src_valid_o, dst_valid_o}));

  assert_src_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    src_valid_o && !src_ready_i && !abort_i |=> src_valid_o && $stable(src_addr_o));

  assert_dst_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dst_valid_o && !dst_ready_i && !abort_i |=> dst_valid_o && $stable(dst_addr_o));

  assert_count_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dst_valid_o && dst_ready_i && !abort_i |=> count_o == $past(count_o) - CW'(1));

  assert_done_state_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (count_o == '1) && !busy_o);

  assert_done_single_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_abort_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && abort_i |=> !busy_o && !done_o);

  assert_simple_no_src_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && (mode_q == FILL_SIMPLE) |-> !src_valid_o);

  assert_refuse_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |-> !busy_o && !done_o);
endmodule

bind blit_addr_seq blit_addr_seq_chk #(.AW(AW), .CW(CW)) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .abort_i    (abort_i),
  .src_valid_o(src_valid_o),
  .src_ready_i(src_ready_i),
  .src_addr_o (src_addr_o),
  .dst_valid_o(dst_valid_o),
  .dst_ready_i(dst_ready_i),
  .dst_addr_o (dst_addr_o),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .cfg_err_o  (cfg_err_o),
  .count_o    (count_o),
  .mode_q     (mode_q)
);

// File: tb/blit_addr_seq_tb.sv
`timescale 1ns/1ps
module blit_addr_seq_tb_top;
  localparam int AW = 24;
  localparam int SW = 12;
  localparam int CW = 24;
  localparam logic [AW-1:0] MSK = 24'h3FFFF0;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start, abort_r;
  logic [SW-1:0] line_len, sstr, dstr;
  logic [CW-1:0] cnt_m1;
  logic [AW-1:0] sbase, dbase, poff, noff;
  logic          skip_en, off_s, off_d, sfill, mfill;
  logic [1:0]    skip_sel;
  logic          s_valid, s_ready, d_valid, d_ready;
  logic [AW-1:0] s_addr, d_addr, s_cur, d_cur;
  logic          busy, done, cerr;
  logic [CW-1:0] count;

  int checks = 0;
  int errors = 0;
  int unsigned rnd = 32'h1234_5678;

  always #2 clk = ~clk;

  blit_addr_seq dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .abort_i(abort_r),
    .line_len_i(line_len), .src_stride_i(sstr), .dst_stride_i(dstr),
    .count_m1_i(cnt_m1), .src_base_i(sbase), .dst_base_i(dbase),
    .pos_off_i(poff), .neg_off_i(noff), .skip_en_i(skip_en), .skip_sel_i(skip_sel),
    .off_src_en_i(off_s), .off_dst_en_i(off_d), .simple_fill_i(sfill),
    .masked_fill_i(mfill), .src_valid_o(s_valid), .src_ready_i(s_ready),
    .src_addr_o(s_addr), .dst_valid_o(d_valid), .dst_ready_i(d_ready),
    .dst_addr_o(d_addr), .busy_o(busy), .done_o(done), .cfg_err_o(cerr),
    .count_o(count), .src_cur_o(s_cur), .dst_cur_o(d_cur)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] disp(input bit en);
    return en ? (poff & MSK) - (noff & MSK) : '0;
  endfunction

  function automatic int gapf(input int m, input bit se, input int sel);
    int n = 1 << sel;
    return se ? (m / n) * 2 * n + (m % n) : m;
  endfunction

  // mode: 0 copy, 1 simple fill, 2 masked fill, 3 both fill bits
  task automatic setup(input int mode, input int skp, input int ll, input int tot,
                       input bit os, input bit od);
    line_len = SW'(ll);
    sstr     = 12'd18;
    dstr     = 12'd20;
    cnt_m1   = CW'(tot - 1);
    sbase    = 24'h01_2000 + AW'(mode * 24'h100);
    dbase    = 24'h40_0800 + AW'(skp * 24'h40);
    poff     = 24'h00_0123;
    noff     = 24'h00_005F;
    skip_en  = (skp != 0);
    skip_sel = (skp != 0) ? 2'(skp - 1) : 2'd0;
    off_s    = os;
    off_d    = od;
    sfill    = (mode == 1) || (mode == 3);
    mfill    = (mode == 2) || (mode == 3);
  endtask

  task automatic run(input int mode, input int skp, input int ll, input int tot,
                     input bit os, input bit od, input int abort_at);
    int nsrc = 0;
    int ndst = 0;
    int exp_src = 0;
    int overlap = 0;
    bit masked = (mode == 2);
    bit nosrc  = (mode == 1) || (mode == 3);
    int step   = masked ? 20 >> 3 : 18;
    string tag;
    tag = nosrc ? "R7" : masked ? "R8" : (skp != 0) ? "R5" : (ll == 0) ? "R3" : "R4";
    if (os || od) tag = {tag, "/R6"};
    for (int k = 0; k < tot; k++) begin
      int p = (ll != 0) ? k % ll : k;
      if (!nosrc && (!masked || (p % 8 == 0))) exp_src++;
    end
    setup(mode, skp, ll, tot, os, od);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R1 busy after start", 32'(busy), 32'd1);
    chk(s_cur == sbase && d_cur == dbase, "R6 live regs hold base",
        {8'h0, s_cur}, {8'h0, sbase});
    chk(count == cnt_m1, "R2 count loaded", 32'(count), 32'(cnt_m1));
    while (busy) begin
      bit sr, dr;
      rnd = rnd * 32'd1103515245 + 32'd12345;
      sr = rnd[16];
      dr = rnd[21];
      if (abort_at >= 0 && ndst == abort_at) begin
        abort_r = 1'b1;
        s_ready = 1'b0;
        d_ready = 1'b0;
        @(negedge clk);
        abort_r = 1'b0;
        chk(!busy && !done, "R9 idle after abort", {30'd0, busy, done}, 32'd0);
        chk(count == CW'(tot - 1 - ndst), "R9 count kept", 32'(count), 32'(tot - 1 - ndst));
        @(negedge clk);
        chk(!done, "R9 no done pulse", 32'(done), 32'd0);
        return;
      end
      s_ready = sr;
      d_ready = dr;
      if (s_valid && d_valid) overlap++;
      if (s_valid && sr) begin
        int rpl = (ll + 7) / 8;
        int line, m;
        logic [AW-1:0] e;
        if (masked) begin
          line = (ll != 0) ? nsrc / rpl : 0;
          m    = (ll != 0) ? nsrc % rpl : nsrc;
        end else begin
          line = (ll != 0) ? nsrc / ll : 0;
          m    = (ll != 0) ? nsrc % ll : nsrc;
        end
        e = sbase + AW'(line * step) + AW'(gapf(m, skip_en, int'(skip_sel))) + disp(os);
        chk(s_addr == e, $sformatf("%s src read %0d", tag, nsrc), {8'h0, s_addr}, {8'h0, e});
        nsrc++;
      end
      if (d_valid && dr) begin
        int line = (ll != 0) ? ndst / ll : 0;
        int p    = (ll != 0) ? ndst % ll : ndst;
        logic [AW-1:0] e;
        e = dbase + AW'(line * 20) + AW'(p) + disp(od);
        chk(d_addr == e, $sformatf("%s dst write %0d", tag, ndst), {8'h0, d_addr}, {8'h0, e});
        ndst++;
      end
      @(negedge clk);
    end
    s_ready = 1'b0;
    d_ready = 1'b0;
    chk(done && count == '1, "R1 done with count all ones", {7'd0, done, count}, 32'h01FF_FFFF);
    chk(ndst == tot, "R2 write total", 32'(ndst), 32'(tot));
    chk(nsrc == exp_src, $sformatf("%s source read total", tag), 32'(nsrc), 32'(exp_src));
    chk(overlap == 0, "R11 exclusive requests", 32'(overlap), 32'd0);
    @(negedge clk);
    chk(!done, "R1 done single cycle", 32'(done), 32'd0);
  endtask

  task automatic refuse(input int mode, input int ll, input int ss, input int ds, input bit exp_err);
    setup(mode, 0, ll, 16, 1'b0, 1'b0);
    sstr  = SW'(ss);
    dstr  = SW'(ds);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(cerr == exp_err, "R10 refusal pulse", 32'(cerr), 32'(exp_err));
    chk(busy == !exp_err, "R10 busy after start", 32'(busy), 32'(!exp_err));
    if (busy) begin
      abort_r = 1'b1;
      @(negedge clk);
      abort_r = 1'b0;
    end
    @(negedge clk);
    chk(!cerr && !busy, "R10 pulse ends", {30'd0, cerr, busy}, 32'd0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R1 watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n   = 1'b0;
    start   = 1'b0;
    abort_r = 1'b0;
    s_ready = 1'b0;
    d_ready = 1'b0;
    setup(0, 0, 0, 8, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !cerr && !s_valid && !d_valid, "R1 reset state",
        {27'd0, busy, done, cerr, s_valid, d_valid}, 32'd0);
    for (int mode = 0; mode < 4; mode++) begin
      for (int skp = 0; skp < 5; skp++) begin
        for (int li = 0; li < 3; li++) begin
          int ll  = (li == 0) ? 0 : (li == 1) ? 5 : 16;
          int sel = mode * 15 + skp * 3 + li;
          run(mode, skp, ll, 40, sel[0], sel[1], -1);
        end
      end
    end
    run(0, 0, 5, 40, 1'b0, 1'b0, 7);
    run(2, 2, 16, 40, 1'b1, 1'b0, 19);
    refuse(0, 8, 12, 4, 1'b1);
    refuse(0, 8, 4, 20, 1'b1);
    refuse(2, 8, 2, 20, 1'b0);
    refuse(1, 8, 0, 20, 1'b0);
    refuse(0, 0, 0, 0, 1'b0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule